// File: doc/BRIEF.md
# Programmable CRT raster timing generator

The block turns a dot-clock enable into the complete raster timing of a cathode-ray or compatible display. A 3-bit dot counter divides each character cell into eight dots. A character counter spans one scan line, and a scanline counter spans one frame. Twelve plain binary thresholds set the timing. There are six per axis, in character units horizontally and in scanline units vertically. From these thresholds the block decodes the active picture, the blanking interval, the horizontal and vertical retrace pulses, and the overscan border that surrounds the picture.

The twelve thresholds are taken into internal copies in two cases: while reset is held, and on the clock edge that closes a frame. Software can therefore rewrite them at any time, and every frame is still built from one consistent set. The counters, the dot index and a one-cycle start-of-frame pulse are brought out so that a pixel fetch stage can follow the raster.

Top module: `crt_raster_timer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the dot index, character count and line count are 0 and frame_start is 0.
- R2: The dot index advances by one on each clock with dot_en high and wraps from 7 to 0. The character count advances only when the dot index wraps. With dot_en low, all counters hold their values.
- R3: When the character count equals h_total-1 and a dot wrap occurs, the character count returns to 0 and the line count advances. A line therefore lasts 8*h_total enabled dots.
- R4: When a line ends while the line count equals v_total-1, both counters return to 0. frame_start is high for exactly one clock, in the first cycle of the new frame. A frame lasts 8*h_total*v_total enabled dots.
- R5: hsync is high exactly when h_sync_beg <= char_cnt < h_sync_end. vsync is high exactly when v_sync_beg <= line_cnt < v_sync_end.
- R6: blank is high when h_blank_beg <= char_cnt < h_blank_fin, or when v_blank_beg <= line_cnt < v_blank_fin.
- R7: active is high only when char_cnt < h_disp_end and line_cnt < v_disp_end.
- R8: overscan is high exactly when both active and blank are low. On each axis this covers the span from the display end to the blanking start.
- R9: The twelve threshold inputs take effect only from the first cycle of a frame. A change made mid-frame alters nothing until the next frame begins.
- R10: The 640x480 reference values are horizontal 80/81/84/96/99/100 and vertical 480/487/489/498/516/525. They give an 800-dot line and a 525-line frame, and a reduced set (72/79 horizontal, 432/474 vertical) keeps both periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dot_en | input | 1 | One enabled dot per clock when high |
| h_disp_end | input | HW | Character count where the picture ends |
| h_blank_beg | input | HW | Character count where horizontal blanking starts |
| h_sync_beg | input | HW | Character count where horizontal retrace starts |
| h_sync_end | input | HW | Character count where horizontal retrace stops |
| h_blank_fin | input | HW | Character count where horizontal blanking stops |
| h_total | input | HW | Characters per line |
| v_disp_end | input | VW | Line count where the picture ends |
| v_blank_beg | input | VW | Line count where vertical blanking starts |
| v_sync_beg | input | VW | Line count where vertical retrace starts |
| v_sync_end | input | VW | Line count where vertical retrace stops |
| v_blank_fin | input | VW | Line count where vertical blanking stops |
| v_total | input | VW | Lines per frame |
| active | output | 1 | Picture area |
| blank | output | 1 | Blanking interval on either axis |
| hsync | output | 1 | Horizontal retrace |
| vsync | output | 1 | Vertical retrace |
| overscan | output | 1 | Border area |
| char_cnt | output | HW | Current character count |
| line_cnt | output | VW | Current line count |
| dot_idx | output | 3 | Dot position inside the character |
| frame_start | output | 1 | One-cycle pulse at the first cycle of a frame |

## Verification
Two events can fall on the same clock edge: the frame wrap and the reload of the thresholds. The bench provokes this by rewriting h_total and v_disp_end in the middle of a frame. It then judges every cycle against an arithmetic model that switches to the new values only after the wrap. In the reduced horizontal timing, the retrace starts inside the border region. The per-cycle comparison then shows hsync and overscan high together, with active and blank low. Dot-enable gaps are mixed in at random, to show that the counters hold while dot_en is low.

// File: rtl/crt_raster_timer.sv
module crt_raster_timer #(
  parameter int HW = 8,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dot_en,
  input  logic [HW-1:0] h_disp_end,
  input  logic [HW-1:0] h_blank_beg,
  input  logic [HW-1:0] h_sync_beg,
  input  logic [HW-1:0] h_sync_end,
  input  logic [HW-1:0] h_blank_fin,
  input  logic [HW-1:0] h_total,
  input  logic [VW-1:0] v_disp_end,
  input  logic [VW-1:0] v_blank_beg,
  input  logic [VW-1:0] v_sync_beg,
  input  logic [VW-1:0] v_sync_end,
  input  logic [VW-1:0] v_blank_fin,
  input  logic [VW-1:0] v_total,
  output logic          active,
  output logic          blank,
  output logic          hsync,
  output logic          vsync,
  output logic          overscan,
  output logic [HW-1:0] char_cnt,
  output logic [VW-1:0] line_cnt,
  output logic [2:0]    dot_idx,
  output logic          frame_start
);
  logic [2:0]    dot_q;
  logic [HW-1:0] chr_q;
  logic [VW-1:0] ln_q;
  logic          fs_q;
  logic [HW-1:0] hde_q, hbs_q, hss_q, hse_q, hbf_q, ht_q;
  logic [VW-1:0] vde_q, vbs_q, vss_q, vse_q, vbf_q, vt_q;

  wire last_dot  = dot_en && (dot_q == 3'd7);
  wire line_end  = last_dot && (chr_q == ht_q - HW'(1));
  wire frame_end = line_end && (ln_q == vt_q - VW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot_q <= '0;
      chr_q <= '0;
      ln_q  <= '0;
      fs_q  <= 1'b0;
    end else begin
      fs_q <= frame_end;
      if (dot_en)   dot_q <= dot_q + 3'd1;
      if (last_dot) chr_q <= line_end ? '0 : chr_q + HW'(1);
      if (line_end) ln_q  <= frame_end ? '0 : ln_q + VW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || frame_end) begin
      hde_q <= h_disp_end;  hbs_q <= h_blank_beg; hss_q <= h_sync_beg;
      hse_q <= h_sync_end;  hbf_q <= h_blank_fin; ht_q  <= h_total;
      vde_q <= v_disp_end;  vbs_q <= v_blank_beg; vss_q <= v_sync_beg;
      vse_q <= v_sync_end;  vbf_q <= v_blank_fin; vt_q  <= v_total;
    end
  end

  wire h_pic = chr_q < hde_q;
  wire v_pic = ln_q < vde_q;
  wire h_blk = (chr_q >= hbs_q) && (chr_q < hbf_q);
  wire v_blk = (ln_q >= vbs_q) && (ln_q < vbf_q);

  assign hsync       = (chr_q >= hss_q) && (chr_q < hse_q);
  assign vsync       = (ln_q >= vss_q) && (ln_q < vse_q);
  assign active      = h_pic && v_pic;
  assign blank       = h_blk || v_blk;
  assign overscan    = !active && !blank;
  assign char_cnt    = chr_q;
  assign line_cnt    = ln_q;
  assign dot_idx     = dot_q;
  assign frame_start = fs_q;

  // R2
  dot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> $stable(dot_idx) && $stable(char_cnt) && $stable(line_cnt));

  // R3
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_en && dot_idx == 3'd7 && char_cnt == ht_q - HW'(1)) |=> char_cnt == '0);

  // R4
  fs_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (char_cnt == '0 && line_cnt == '0 && dot_idx == 3'd0));

  // R4
  fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R9
  param_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !frame_start) |-> ($stable(ht_q) && $stable(vt_q) && $stable(hde_q) && $stable(vde_q)));

  // R7
  active_unblanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hbs_q >= hde_q && vbs_q >= vde_q) |-> !blank);
endmodule

// File: tb/crt_raster_timer_test.sv
module crt_raster_timer_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, dot_en = 1'b0;
  logic [7:0] h_in [6];
  logic [9:0] v_in [6];
  logic act_o, blk_o, hs_o, vs_o, ovs_o, fs_o;
  logic [7:0] chr_o;
  logic [9:0] ln_o;
  logic [2:0] dot_o;

  int checks = 0, fails = 0;
  int act_h [6];
  int act_v [6];
  int n = 0, cyc = 0;
  bit fs_exp = 0, pend = 0, meas = 0;
  int hs_rise = -1, vs_rise = -1, fs_last = -1;
  bit hs_p = 0, vs_p = 0;

  crt_raster_timer uut (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en),
    .h_disp_end(h_in[0]), .h_blank_beg(h_in[1]), .h_sync_beg(h_in[2]),
    .h_sync_end(h_in[3]), .h_blank_fin(h_in[4]), .h_total(h_in[5]),
    .v_disp_end(v_in[0]), .v_blank_beg(v_in[1]), .v_sync_beg(v_in[2]),
    .v_sync_end(v_in[3]), .v_blank_fin(v_in[4]), .v_total(v_in[5]),
    .active(act_o), .blank(blk_o), .hsync(hs_o), .vsync(vs_o), .overscan(ovs_o),
    .char_cnt(chr_o), .line_cnt(ln_o), .dot_idx(dot_o), .frame_start(fs_o));

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, actual, expected);
    end
  endtask

  task automatic set_h(int a, int b, int c, int d, int e, int f);
    h_in[0] = 8'(a); h_in[1] = 8'(b); h_in[2] = 8'(c);
    h_in[3] = 8'(d); h_in[4] = 8'(e); h_in[5] = 8'(f);
  endtask

  task automatic set_v(int a, int b, int c, int d, int e, int f);
    v_in[0] = 10'(a); v_in[1] = 10'(b); v_in[2] = 10'(c);
    v_in[3] = 10'(d); v_in[4] = 10'(e); v_in[5] = 10'(f);
  endtask

  task automatic load_act();
    for (int i = 0; i < 6; i++) begin
      act_h[i] = int'(h_in[i]);
      act_v[i] = int'(v_in[i]);
    end
  endtask

  task automatic do_reset(bit measure);
    @(negedge clk);
    rst_n = 1'b0; dot_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 dot", int'(dot_o), 0);
    check("R1 char", int'(chr_o), 0);
    check("R1 line", int'(ln_o), 0);
    check("R1 fs", int'(fs_o), 0);
    rst_n = 1'b1;
    load_act();
    n = 0; pend = 0; fs_exp = 0; meas = measure; cyc = 0;
    hs_rise = -1; vs_rise = -1; fs_last = -1; hs_p = 0; vs_p = 0;
  endtask

  task automatic step(bit en);
    int hl, fl, d, c, l;
    @(negedge clk);
    if (pend) begin load_act(); pend = 0; end
    hl = act_h[5];
    fl = 8 * act_h[5] * act_v[5];
    d = n % 8; c = (n / 8) % hl; l = n / (8 * hl);
    check("R2 dot_idx", int'(dot_o), d);
    check("R3 char_cnt", int'(chr_o), c);
    check("R4 line_cnt", int'(ln_o), l);
    check("R4 frame_start", int'(fs_o), int'(fs_exp));
    check("R5 hsync", int'(hs_o), int'(c >= act_h[2] && c < act_h[3]));
    check("R5 vsync", int'(vs_o), int'(l >= act_v[2] && l < act_v[3]));
    check("R6 blank", int'(blk_o), int'((c >= act_h[1] && c < act_h[4]) || (l >= act_v[1] && l < act_v[4])));
    check("R7 active", int'(act_o), int'(c < act_h[0] && l < act_v[0]));
    check("R8 overscan", int'(ovs_o), int'(!act_o && !blk_o));
    if (meas) begin
      if (hs_o && !hs_p) begin
        if (hs_rise >= 0) check("R10 line period", cyc - hs_rise, 8 * hl);
        hs_rise = cyc;
      end
      if (!hs_o && hs_p && hs_rise >= 0) check("R5 hsync width", cyc - hs_rise, 8 * (act_h[3] - act_h[2]));
      if (vs_o && !vs_p) begin
        if (vs_rise >= 0) check("R10 frame period", cyc - vs_rise, fl);
        vs_rise = cyc;
      end
      if (!vs_o && vs_p && vs_rise >= 0) check("R5 vsync width", cyc - vs_rise, 8 * hl * (act_v[3] - act_v[2]));
      if (fs_o) begin
        if (fs_last >= 0) check("R4 frame_start period", cyc - fs_last, fl);
        fs_last = cyc;
      end
    end
    hs_p = hs_o; vs_p = vs_o;
    cyc++;
    dot_en = en;
    fs_exp = 0;
    if (en) begin
      n++;
      if (n == fl) begin n = 0; pend = 1; fs_exp = 1; end
    end
  endtask

  task automatic run(int steps);
    for (int i = 0; i < steps; i++) step(1'b1);
  endtask

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R10 reference horizontal timing, short frame
    set_h(80, 81, 84, 96, 99, 100);
    set_v(3, 4, 4, 5, 5, 6);
    do_reset(1'b1);
    run(3 * 4800 + 5);
    // R10 reduced horizontal timing; retrace overlaps border
    set_h(72, 81, 79, 96, 99, 100);
    do_reset(1'b1);
    run(3 * 4800 + 5);
    // R10 reference vertical timing, short line
    set_h(1, 2, 2, 3, 4, 5);
    set_v(480, 487, 489, 498, 516, 525);
    do_reset(1'b1);
    run(2 * 21000 + 5);
    // R10 reduced vertical timing
    set_v(432, 487, 474, 498, 516, 525);
    do_reset(1'b1);
    run(21000 + 10);
    // R2 dot enable gaps
    set_h(2, 3, 3, 4, 5, 6);
    set_v(2, 3, 3, 4, 4, 5);
    do_reset(1'b0);
    for (int i = 0; i < 3000; i++) step(1'($urandom_range(0, 1)));
    // R9 mid-frame rewrite takes effect at the next frame only
    do_reset(1'b0);
    run(100);
    h_in[5] = 8'd7;
    v_in[0] = 10'd1;
    run(500);
    h_in[5] = 8'd5;
    run(700);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule